// File: doc/BRIEF.md
# Indirect-Access 64-Source Interrupt Controller

This block collects up to 64 interrupt request lines, qualifies each one by a per-source mask and a per-source trigger mode, and raises a single request to the processor together with a vector address for the winning source. Software reaches the mask and trigger-mode state only through an indirect register pair: it first writes an internal register address into a select register, then reads or writes the selected 64-bit register through a data window.

Edge-mode sources latch a pending flag on a rising input edge; level-mode sources request for as long as their input is high. Among the pending, unmasked sources the lowest-numbered one is taken into service. While a source is in service the request to the processor stays high with a stable vector, and nothing else is taken until software writes that source's number to the acknowledge port. The vector of source n is 0x800 + 1024 × instance index + 16 × n.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the select register reads 0, the mask register (internal address 0x40) reads all ones, the trigger-mode register (internal address 0x50) reads all zeros, and `cpu_irq` is low.
- R2: A write with `wr_sel`=0 loads the select register from `wr_data[7:0]`, which reads back on `rd_sel`=0; a write or read with `wr_sel`/`rd_sel`=1 reaches the internal register named by the select register, bit n belonging to source n.
- R3: A source whose mask bit is 1 is never taken into service; clearing the bit lets its pending request through.
- R4: A trigger-mode bit of 1 makes the source level-triggered: it requests only while its input is high and leaves no pending state behind after the input falls.
- R5: A trigger-mode bit of 0 makes the source edge-triggered: a rising input edge sets a pending flag that survives the input falling and masking, and is cleared only when the source is taken into service.
- R6: When several eligible sources request at once, the lowest-numbered one is taken; the others stay pending.
- R7: While a source is in service, `cpu_irq` stays high and `cpu_vec` is stable; no other source is taken and a write to the acknowledge port (`wr_sel`=2) with a different number has no effect. A write with the in-service number ends service one clock later.
- R8: While source n is in service, `cpu_vec` equals 0x800 + 1024 × `INST_IDX` + 16 × n.
- R9: Through the data window, internal addresses other than 0x40 and 0x50 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Request lines, one per source, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 select, 1 data window, 2 acknowledge |
| wr_data | input | 64 | Write data (select uses bits 7:0, acknowledge bits 5:0) |
| rd_sel | input | 2 | Read source: 0 select, 1 data window, other values read zero |
| rd_data | output | 64 | Read data, combinational from rd_sel |
| cpu_irq | output | 1 | Request to the processor, high while a source is in service |
| cpu_vec | output | 16 | Vector address of the in-service source |

## Verification
Every source is driven alone in edge mode and then in level mode, which separates a wrong vector scale or offset from a wrong source index and shows that level requests leave nothing behind. Adjacent source pairs raised together tell a lowest-first picker from any other order, and a lower source arriving during service tells a non-preemptive design from a preemptive one. Pulses on masked sources separate the latched edge state from the transparent level state, and writes through unused internal addresses show whether the address decode is complete.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_WIN   = 2'd1,
    SEL_ACK   = 2'd2
  } port_sel_e;

  localparam logic [7:0] IADR_MASK = 8'h40;
  localparam logic [7:0] IADR_TRIG = 8'h50;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [1:0]      rd_sel_i,
  output logic [NSRC-1:0] rd_data_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] trig_o,
  output logic            ack_stb_o,
  output logic [IDW-1:0]  ack_id_o
);
  logic [AW-1:0]   idx_q, idx_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] trig_q, trig_d;
  logic            idx_en, mask_en, trig_en;

  always_comb begin
    idx_en  = wr_en_i && (wr_sel_i == SEL_INDEX);
    mask_en = wr_en_i && (wr_sel_i == SEL_WIN) && (idx_q == IADR_MASK);
    trig_en = wr_en_i && (wr_sel_i == SEL_WIN) && (idx_q == IADR_TRIG);
    idx_d   = wr_data_i[AW-1:0];
    mask_d  = wr_data_i;
    trig_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= '1;
      trig_q <= '0;
    end else begin
      if (idx_en)  idx_q  <= idx_d;
      if (mask_en) mask_q <= mask_d;
      if (trig_en) trig_q <= trig_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_INDEX: rd_data_o = NSRC'(idx_q);
      SEL_WIN: begin
        if (idx_q == IADR_MASK)      rd_data_o = mask_q;
        else if (idx_q == IADR_TRIG) rd_data_o = trig_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign mask_o    = mask_q;
  assign trig_o    = trig_q;
  assign ack_stb_o = wr_en_i && (wr_sel_i == SEL_ACK);
  assign ack_id_o  = wr_data_i[IDW-1:0];

  AST_UNUSED_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_WIN && idx_q != IADR_MASK && idx_q != IADR_TRIG)
      |=> ($stable(mask_q) && $stable(trig_q))); // R9
endmodule

// File: rtl/irq_vec_pending.sv
module irq_vec_pending #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic [NSRC-1:0] trig_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC-1:0] prev_q, prev_d;
  logic [NSRC-1:0] epend_q, epend_d;
  logic [NSRC-1:0] rise;

  always_comb begin
    prev_d  = irq_i;
    rise    = irq_i & ~prev_q & ~trig_i;
    epend_d = (epend_q & ~take_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      epend_q <= '0;
    end else begin
      prev_q  <= prev_d;
      epend_q <= epend_d;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign req_o[s] = trig_i[s] ? irq_i[s] : epend_q[s];
  end

  AST_EDGE_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(epend_q) & ~$past(take_i)) & ~epend_q) == '0)); // R5
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
  parameter int NSRC = 64,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            ack_stb_i,
  input  logic [IDW-1:0]  ack_id_i,
  output logic [NSRC-1:0] take_o,
  output logic            busy_o,
  output logic [IDW-1:0]  svc_id_o
);
  logic [NSRC-1:0] elig;
  logic [IDW-1:0]  pick;
  logic            any;
  logic            busy_q, busy_d;
  logic [IDW-1:0]  svc_q, svc_d;
  logic            svc_en;
  logic            ack_hit;

  always_comb begin
    elig = req_i & ~mask_i;
    pick = '0;
    any  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick = IDW'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    ack_hit = busy_q && ack_stb_i && (ack_id_i == svc_q);
    take_o  = (!busy_q && any) ? (NSRC'(1) << pick) : '0;
    svc_en  = !busy_q && any;
    svc_d   = pick;
    busy_d  = busy_q;
    if (ack_hit)      busy_d = 1'b0;
    else if (svc_en)  busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      svc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (svc_en) svc_q <= svc_d;
    end
  end

  assign busy_o   = busy_q;
  assign svc_id_o = svc_q;

  AST_HOLD_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(ack_stb_i && ack_id_i == svc_q)) |=> (busy_q && $stable(svc_q))); // R7
  AST_NO_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (($past(mask_i) & (NSRC'(1) << svc_q)) == '0)); // R3
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o)); // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o != '0) |-> (((take_o - NSRC'(1)) & elig) == '0)); // R6
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NSRC     = 64,
  parameter int INST_IDX = 0,
  parameter int VW       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     irq_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [63:0]     wr_data,
  input  logic [1:0]      rd_sel,
  output logic [63:0]     rd_data,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_vec
);
  localparam int IDW = $clog2(NSRC);
  localparam logic [VW-1:0] VBASE = VW'(32'h800 + 1024 * INST_IDX);

  logic [NSRC-1:0] mask, trig, req, take;
  logic            ack_stb;
  logic [IDW-1:0]  ack_id;
  logic            busy;
  logic [IDW-1:0]  svc_id;

  irq_vec_regs #(.NSRC(NSRC)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data[NSRC-1:0]),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data[NSRC-1:0]),
    .mask_o(mask), .trig_o(trig), .ack_stb_o(ack_stb), .ack_id_o(ack_id)
  );

  irq_vec_pending #(.NSRC(NSRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_in[NSRC-1:0]), .trig_i(trig),
    .take_i(take), .req_o(req)
  );

  irq_vec_arbiter #(.NSRC(NSRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask),
    .ack_stb_i(ack_stb), .ack_id_i(ack_id), .take_o(take),
    .busy_o(busy), .svc_id_o(svc_id)
  );

  if (NSRC < 64) begin : g_pad
    assign rd_data[63:NSRC] = '0;
  end

  assign cpu_irq = busy;
  assign cpu_vec = VBASE + (VW'(svc_id) << 4);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  localparam int INST = 1;
  localparam int BASE = 'h800 + 1024 * INST;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        cpu_irq;
  logic [15:0] cpu_vec;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl #(.INST_IDX(INST)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_reg(input logic [7:0] adr, input logic [63:0] d);
    wr(2'd0, 64'(adr));
    wr(2'd1, d);
  endtask

  task automatic get_reg(input logic [7:0] adr, output logic [63:0] d);
    wr(2'd0, 64'(adr));
    rd(2'd1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1: reset state
    rd(2'd0, v); chk("R1 select", v, 64'h0);
    chk("R1 irq", 64'(cpu_irq), 64'h0);
    get_reg(8'h40, v); chk("R1 mask", v, '1);
    get_reg(8'h50, v); chk("R1 trig", v, 64'h0);

    // R2: indirect access
    wr(2'd0, 64'h50); rd(2'd0, v); chk("R2 select readback", v, 64'h50);
    set_reg(8'h40, 64'hA5A5_0F0F_1234_FFFF);
    get_reg(8'h40, v); chk("R2 mask readback", v, 64'hA5A5_0F0F_1234_FFFF);
    set_reg(8'h50, 64'h0123_4567_89AB_CDEF);
    get_reg(8'h50, v); chk("R2 trig readback", v, 64'h0123_4567_89AB_CDEF);
    rd(2'd2, v); chk("R2 other port", v, 64'h0);

    // R9: unused internal addresses
    foreach (v[i]) ; // no-op keeps v declared use simple
    for (int a = 0; a < 256; a += 8) begin
      if (a == 'h40 || a == 'h50) continue;
      set_reg(8'(a), '1);
      rd(2'd1, v); chk("R9 unused reads zero", v, 64'h0);
    end
    get_reg(8'h40, v); chk("R9 mask untouched", v, 64'hA5A5_0F0F_1234_FFFF);
    get_reg(8'h50, v); chk("R9 trig untouched", v, 64'h0123_4567_89AB_CDEF);

    // all edge, all unmasked
    set_reg(8'h50, 64'h0);
    set_reg(8'h40, 64'h0);

    // R5/R8: edge sweep over every source
    for (int n = 0; n < 64; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      wait_n(3);
      chk("R8 edge vector", 64'(cpu_vec), 64'(BASE + 16 * n));
      irq_in[n] = 1'b0;
      wr(2'd2, 64'(n ^ 1));
      wait_n(1);
      chk("R7 wrong ack ignored", {cpu_irq, 47'd0, cpu_vec}, {1'b1, 47'd0, 16'(BASE + 16 * n)});
      wr(2'd2, 64'(n));
      chk("R7 ack ends service", 64'(cpu_irq), 64'h0);
      wait_n(2);
      chk("R5 no repend", 64'(cpu_irq), 64'h0);
    end

    // R6: adjacent pairs, lower first, other stays pending
    for (int n = 0; n < 63; n++) begin
      @(negedge clk); irq_in[n] = 1'b1; irq_in[n+1] = 1'b1;
      wait_n(3);
      chk("R6 lower wins", 64'(cpu_vec), 64'(BASE + 16 * n));
      irq_in[n] = 1'b0; irq_in[n+1] = 1'b0;
      wr(2'd2, 64'(n));
      wait_n(2);
      chk("R6 other kept", {cpu_irq, 47'd0, cpu_vec}, {1'b1, 47'd0, 16'(BASE + 16 * (n + 1))});
      wr(2'd2, 64'(n + 1));
      wait_n(1);
    end

    // R7: no preemption by a lower source
    @(negedge clk); irq_in[10] = 1'b1;
    wait_n(3); irq_in[10] = 1'b0;
    @(negedge clk); irq_in[3] = 1'b1;
    wait_n(3); irq_in[3] = 1'b0;
    chk("R7 no preempt", 64'(cpu_vec), 64'(BASE + 16 * 10));
    wr(2'd2, 64'd10);
    wait_n(2);
    chk("R7 next after ack", {cpu_irq, 47'd0, cpu_vec}, {1'b1, 47'd0, 16'(BASE + 16 * 3)});
    wr(2'd2, 64'd3);

    // R3/R5: masked edge pulse is held, released by unmask
    set_reg(8'h40, '1);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); irq_in[5] = 1'b0;
    wait_n(3);
    chk("R3 masked not taken", 64'(cpu_irq), 64'h0);
    set_reg(8'h40, ~(64'd1 << 5));
    wait_n(2);
    chk("R5 held edge taken", {cpu_irq, 47'd0, cpu_vec}, {1'b1, 47'd0, 16'(BASE + 16 * 5)});
    wr(2'd2, 64'd5);

    // R4: masked level pulse leaves nothing behind
    set_reg(8'h40, '1);
    set_reg(8'h50, 64'd1 << 9);
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk); irq_in[9] = 1'b0;
    set_reg(8'h40, ~(64'd1 << 9));
    wait_n(3);
    chk("R4 level not latched", 64'(cpu_irq), 64'h0);

    // R4/R8: level sweep
    set_reg(8'h50, '1);
    set_reg(8'h40, 64'h0);
    for (int n = 0; n < 64; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      wait_n(2);
      chk("R4 level vector", {cpu_irq, 47'd0, cpu_vec}, {1'b1, 47'd0, 16'(BASE + 16 * n)});
      irq_in[n] = 1'b0;
      wr(2'd2, 64'(n));
      wait_n(2);
      chk("R4 level released", 64'(cpu_irq), 64'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule